// File: doc/BRIEF.md
# Dual Test-Register Self-Test Sequencer

This block runs a complete built-in self-test of two combinational networks placed in a ring between two multi-mode test registers. Register A drives network 1, and network 1 feeds register B. Register B drives network 2, and network 2 feeds register A. Each half of the test uses one register as a pseudorandom pattern source. The other register folds the network responses into a signature.

A single-cycle `start` pulse begins the sequence. The sequencer shifts a seed into register A and clears register B. It then runs the first half. Next it shifts register B out through `scan_out`, and in the same cycles it shifts in the second seed and clears register A. It then runs the second half and shifts register A out. Each serial signature is captured and compared with a golden parameter value, and each network gets its own pass flag. The run length, the seeds, the feedback taps and the golden signatures are all parameters.

Both registers use the same update rule when compacting: `next = (q << 1) ^ (q[W-1] ? TAPS : 0) ^ in`. In a register acting as the generator, `in` is forced to zero. Network 1 computes `y = x ^ rotl(x,1) ^ CN_KEY`. Network 2 computes `y = ~(x & rotl(x,3))`.

Top module: `dual_bist_top`

## Requirements
- R1: While `rst` is high and after it falls, `done`, `busy`, `pass_cn1`, `pass_cn2` and `scan_out` are all 0.
- R2: A `start` pulse begins the sequence from the first phase on the next clock, even when a sequence is already in progress. It clears `done`, `pass_cn1` and `pass_cn2`.
- R3: The phases follow a fixed order with fixed lengths: seed load (W cycles), first run (RUN_LEN), first unload (W), second run (RUN_LEN), final unload (W). `busy` is high for exactly 3W+2RUN_LEN cycles after the start edge. `done` rises, and `busy` falls, on the edge that ends the final unload.
- R4: In the seed load, register A receives SEED1 most significant bit first and register B is cleared. In the first run, register A steps with zero input while register B compacts the output of network 1 for RUN_LEN cycles.
- R5: During the first unload, `scan_out` carries the signature of register B, most significant bit first, one bit per cycle. In the same cycles SEED2 is shifted into register B and register A is cleared.
- R6: In the second run, register B steps with zero input while register A compacts the output of network 2 for RUN_LEN cycles.
- R7: During the final unload, `scan_out` carries the signature of register A, most significant bit first.
- R8: `pass_cn1` is set on the edge that ends the first unload, and only if the serial signature equals GOLD1. `pass_cn2` is set on the edge that ends the final unload, and only if its signature equals GOLD2. The two flags are independent.
- R9: Outside the two unload phases, `scan_out` is 0. While idle, `done` and both pass flags hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until next start |
| pass_cn1 | output | 1 | Network 1 signature matched GOLD1 |
| pass_cn2 | output | 1 | Network 2 signature matched GOLD2 |
| scan_out | output | 1 | Serial signature stream during unload phases |

## Verification
Every result is tied to a cycle count k measured from the start edge, with cycle 1 directly after that edge. Signature bit i of register B appears on `scan_out` in cycle W+RUN_LEN+1+i, and signature bit i of register A appears in cycle 2W+2RUN_LEN+1+i. `pass_cn1` first shows its new value in cycle 2W+RUN_LEN+1. `done` and `pass_cn2` show theirs in the cycle after cycle 3W+2RUN_LEN. The bench samples every output on the falling edge of each cycle k and compares it with the value a bench model predicts for that exact k. Restarts reset k to 1, so pass flags that had already been set must read 0 again.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD_A  = 3'd1,
        ST_RUN_1   = 3'd2,
        ST_DUMP_B  = 3'd3,
        ST_RUN_2   = 3'd4,
        ST_DUMP_A  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        RM_HOLD    = 2'd0,
        RM_SHIFT   = 2'd1,
        RM_COMPACT = 2'd2,
        RM_CLEAR   = 2'd3
    } reg_mode_e;

    typedef struct packed {
        reg_mode_e mode;
        logic      sin;
        logic      gen;
    } reg_ctrl_t;

    function automatic seq_state_e next_phase(input seq_state_e s);
        case (s)
            ST_LOAD_A: return ST_RUN_1;
            ST_RUN_1:  return ST_DUMP_B;
            ST_DUMP_B: return ST_RUN_2;
            ST_RUN_2:  return ST_DUMP_A;
            default:   return ST_IDLE;
        endcase
    endfunction

    function automatic logic is_run(input seq_state_e s);
        return (s == ST_RUN_1) || (s == ST_RUN_2);
    endfunction

endpackage

// File: rtl/bist_test_reg.sv
module bist_test_reg
    import bist_pkg::*;
#(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'h1D
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_ctrl_t    ctrl,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] q,
    output logic         sout
);

    logic [W-1:0] fold_in;
    logic [W-1:0] step_q;
    logic [W-1:0] q_nxt;

    always_comb begin
        fold_in = ctrl.gen ? '0 : p_in;
        step_q  = {q[W-2:0], 1'b0} ^ (q[W-1] ? TAPS : '0) ^ fold_in;
        case (ctrl.mode)
            RM_SHIFT:   q_nxt = {q[W-2:0], ctrl.sin};
            RM_COMPACT: q_nxt = step_q;
            RM_CLEAR:   q_nxt = '0;
            default:    q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    assign sout = q[W-1];

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.mode == RM_CLEAR |=> q == '0);

    p_shift_in_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl.mode == RM_SHIFT |=> (q[0] == $past(ctrl.sin)) && (q[W-1:1] == $past(q[W-2:0])));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl.mode == RM_HOLD |=> $stable(q));

endmodule

// File: rtl/bist_comb_net.sv
module bist_comb_net #(
    parameter int           W       = 8,
    parameter int           VARIANT = 0,
    parameter logic [W-1:0] KEY     = 8'hA5
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);

    generate
        if (VARIANT == 0) begin : g_xor_net
            logic [W-1:0] rot1;
            assign rot1 = {x[W-2:0], x[W-1]};
            assign y    = x ^ rot1 ^ KEY;
        end else begin : g_nand_net
            logic [W-1:0] rot3;
            assign rot3 = {x[W-4:0], x[W-1:W-3]};
            assign y    = ~(x & rot3);
        end
    endgenerate

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
    import bist_pkg::*;
#(
    parameter int           W       = 8,
    parameter int           RUN_LEN = 20,
    parameter logic [W-1:0] SEED1   = 8'h81,
    parameter logic [W-1:0] SEED2   = 8'h3C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_e state,
    output logic       last,
    output reg_ctrl_t  ctrl_a,
    output reg_ctrl_t  ctrl_b,
    output logic       busy,
    output logic       done
);

    localparam int LMAX = (W > RUN_LEN) ? W : RUN_LEN;
    localparam int CW   = $clog2(LMAX + 1);
    localparam int IW   = $clog2(W);

    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;

    function automatic logic [CW-1:0] span_of(input seq_state_e s);
        if (is_run(s)) return CW'(RUN_LEN - 1);
        else           return CW'(W - 1);
    endfunction

    assign last = (cnt == '0);
    assign idx  = cnt[IW-1:0];
    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (start) begin
            state <= ST_LOAD_A;
            cnt   <= CW'(W - 1);
            done  <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (last) begin
                state <= next_phase(state);
                cnt   <= span_of(next_phase(state));
                if (state == ST_DUMP_A) done <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_a = '{mode: RM_HOLD, sin: 1'b0, gen: 1'b0};
        ctrl_b = '{mode: RM_HOLD, sin: 1'b0, gen: 1'b0};
        case (state)
            ST_LOAD_A: begin
                ctrl_a = '{mode: RM_SHIFT, sin: SEED1[idx], gen: 1'b0};
                ctrl_b = '{mode: RM_CLEAR, sin: 1'b0, gen: 1'b0};
            end
            ST_RUN_1: begin
                ctrl_a = '{mode: RM_COMPACT, sin: 1'b0, gen: 1'b1};
                ctrl_b = '{mode: RM_COMPACT, sin: 1'b0, gen: 1'b0};
            end
            ST_DUMP_B: begin
                ctrl_a = '{mode: RM_CLEAR, sin: 1'b0, gen: 1'b0};
                ctrl_b = '{mode: RM_SHIFT, sin: SEED2[idx], gen: 1'b0};
            end
            ST_RUN_2: begin
                ctrl_a = '{mode: RM_COMPACT, sin: 1'b0, gen: 1'b0};
                ctrl_b = '{mode: RM_COMPACT, sin: 1'b0, gen: 1'b1};
            end
            ST_DUMP_A: begin
                ctrl_a = '{mode: RM_SHIFT, sin: 1'b0, gen: 1'b0};
            end
            default: ;
        endcase
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == ST_LOAD_A) && !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_IDLE));

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!start && (state != ST_IDLE) && (cnt != '0)) |=> $stable(state));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (cnt < CW'(LMAX)));

endmodule

// File: rtl/bist_sig_check.sv
module bist_sig_check #(
    parameter int           W    = 8,
    parameter logic [W-1:0] GOLD = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift_en,
    input  logic last,
    input  logic sbit,
    output logic pass
);

    logic [W-1:0] cap;
    logic [W-1:0] cap_nxt;

    assign cap_nxt = {cap[W-2:0], sbit};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap  <= '0;
            pass <= 1'b0;
        end else if (clear) begin
            cap  <= '0;
            pass <= 1'b0;
        end else if (shift_en) begin
            cap <= cap_nxt;
            if (last) pass <= (cap_nxt == GOLD);
        end
    end

    p_pass_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!clear && !(shift_en && last)) |=> $stable(pass));

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pass);

endmodule

// File: rtl/dual_bist_top.sv
module dual_bist_top
    import bist_pkg::*;
#(
    parameter int           W       = 8,
    parameter int           RUN_LEN = 20,
    parameter logic [W-1:0] TAPS    = 8'h1D,
    parameter logic [W-1:0] SEED1   = 8'h81,
    parameter logic [W-1:0] SEED2   = 8'h3C,
    parameter logic [W-1:0] CN_KEY  = 8'hA5,
    parameter logic [W-1:0] GOLD1   = '0,
    parameter logic [W-1:0] GOLD2   = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic pass_cn1,
    output logic pass_cn2,
    output logic scan_out
);

    seq_state_e   state;
    logic         last;
    reg_ctrl_t    ctrl_a;
    reg_ctrl_t    ctrl_b;
    logic [W-1:0] q_a;
    logic [W-1:0] q_b;
    logic [W-1:0] net1_y;
    logic [W-1:0] net2_y;
    logic         sout_a;
    logic         sout_b;
    logic         dump_a;
    logic         dump_b;

    bist_seq_ctrl #(.W(W), .RUN_LEN(RUN_LEN), .SEED1(SEED1), .SEED2(SEED2)) u_seq (
        .clk(clk), .rst(rst), .start(start), .state(state), .last(last),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .busy(busy), .done(done)
    );

    bist_test_reg #(.W(W), .TAPS(TAPS)) u_reg_a (
        .clk(clk), .rst(rst), .ctrl(ctrl_a), .p_in(net2_y), .q(q_a), .sout(sout_a)
    );

    bist_test_reg #(.W(W), .TAPS(TAPS)) u_reg_b (
        .clk(clk), .rst(rst), .ctrl(ctrl_b), .p_in(net1_y), .q(q_b), .sout(sout_b)
    );

    bist_comb_net #(.W(W), .VARIANT(0), .KEY(CN_KEY)) u_net1 (.x(q_a), .y(net1_y));
    bist_comb_net #(.W(W), .VARIANT(1), .KEY(CN_KEY)) u_net2 (.x(q_b), .y(net2_y));

    assign dump_a = (state == ST_DUMP_A);
    assign dump_b = (state == ST_DUMP_B);

    bist_sig_check #(.W(W), .GOLD(GOLD1)) u_chk1 (
        .clk(clk), .rst(rst), .clear(start), .shift_en(dump_b), .last(last),
        .sbit(sout_b), .pass(pass_cn1)
    );

    bist_sig_check #(.W(W), .GOLD(GOLD2)) u_chk2 (
        .clk(clk), .rst(rst), .clear(start), .shift_en(dump_a), .last(last),
        .sbit(sout_a), .pass(pass_cn2)
    );

    assign scan_out = dump_b ? sout_b : (dump_a ? sout_a : 1'b0);

    p_no_done_busy_r3: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !scan_out);

endmodule

// File: tb/test_dual_bist_top.sv
module test_dual_bist_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 20;
    localparam int T = 3 * W + 2 * N;
    localparam logic [W-1:0] TAPS  = 8'h1D;
    localparam logic [W-1:0] SEED1 = 8'h81;
    localparam logic [W-1:0] SEED2 = 8'h3C;
    localparam logic [W-1:0] KEY   = 8'hA5;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int s);
        return (x << s) | (x >> (W - s));
    endfunction

    function automatic logic [W-1:0] fold(input logic [W-1:0] q, input logic [W-1:0] p);
        return (q << 1) ^ (q[W-1] ? TAPS : '0) ^ p;
    endfunction

    function automatic logic [W-1:0] model_sig(input int which);
        logic [W-1:0] a, b, na, nb;
        a = SEED1; b = '0;
        for (int i = 0; i < N; i++) begin
            nb = fold(b, a ^ rotl(a, 1) ^ KEY);
            na = fold(a, '0);
            a = na; b = nb;
        end
        if (which == 1) return b;
        b = SEED2; a = '0;
        for (int i = 0; i < N; i++) begin
            na = fold(a, ~(b & rotl(b, 3)));
            nb = fold(b, '0);
            a = na; b = nb;
        end
        return a;
    endfunction

    localparam logic [W-1:0] SIG1 = model_sig(1);
    localparam logic [W-1:0] SIG2 = model_sig(2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, pass_cn1, pass_cn2, scan_out;
    logic busy_x, done_x, pass1_x, pass2_x, scan_x;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_bist_top #(.W(W), .RUN_LEN(N), .TAPS(TAPS), .SEED1(SEED1), .SEED2(SEED2),
                    .CN_KEY(KEY), .GOLD1(SIG1), .GOLD2(SIG2)) i_dual_bist_top (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .pass_cn1(pass_cn1), .pass_cn2(pass_cn2), .scan_out(scan_out)
    );

    dual_bist_top #(.W(W), .RUN_LEN(N), .TAPS(TAPS), .SEED1(SEED1), .SEED2(SEED2),
                    .CN_KEY(KEY), .GOLD1(SIG1), .GOLD2(SIG2 ^ 8'h01)) i_dual_bist_top_bad (
        .clk(clk), .rst(rst), .start(start), .busy(busy_x), .done(done_x),
        .pass_cn1(pass1_x), .pass_cn2(pass2_x), .scan_out(scan_x)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Called at a falling edge; leaves off at the falling edge after the done edge.
    task automatic run_seq(input int abort_at);
        logic exp_so;
        int   k1, k2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (abort_at > 0) begin
            for (int j = 1; j < abort_at; j++) begin
                chk(busy == 1'b1, "R2", "busy before restart", busy, 1);
                @(negedge clk);
            end
            chk(busy == 1'b1 && done == 1'b0, "R2", "busy at restart point", busy, 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 1; k <= T; k++) begin
            k1 = k - (W + N + 1);
            k2 = k - (2 * W + 2 * N + 1);
            if (k1 >= 0 && k1 < W)      exp_so = SIG1[W-1-k1];
            else if (k2 >= 0 && k2 < W) exp_so = SIG2[W-1-k2];
            else                        exp_so = 1'b0;
            chk(busy == 1'b1 && done == 1'b0, "R3", $sformatf("busy/done at k=%0d", k),
                {busy, done}, 2);
            if (k1 >= 0 && k1 < W)
                chk(scan_out == exp_so, "R5", $sformatf("signature 1 bit at k=%0d", k), scan_out, exp_so);
            else if (k2 >= 0 && k2 < W)
                chk(scan_out == exp_so, "R7", $sformatf("signature 2 bit at k=%0d", k), scan_out, exp_so);
            else
                chk(scan_out == 1'b0, "R9", $sformatf("scan_out quiet at k=%0d", k), scan_out, 0);
            chk(pass_cn1 == (k > 2 * W + N), "R8", $sformatf("pass_cn1 at k=%0d", k),
                pass_cn1, int'(k > 2 * W + N));
            chk(pass_cn2 == 1'b0, "R8", $sformatf("pass_cn2 early at k=%0d", k), pass_cn2, 0);
            @(negedge clk);
        end
        chk(done == 1'b1 && busy == 1'b0, "R3", "done after last unload", {busy, done}, 1);
        chk(pass_cn1 == 1'b1, "R4", "network 1 signature matches", pass_cn1, 1);
        chk(pass_cn2 == 1'b1, "R6", "network 2 signature matches", pass_cn2, 1);
        chk(pass1_x == 1'b1, "R8", "bad-gold unit pass_cn1", pass1_x, 1);
        chk(pass2_x == 1'b0, "R8", "bad-gold unit pass_cn2", pass2_x, 0);
        chk(scan_x == scan_out, "R9", "both units scan_out agree", scan_x, scan_out);
    endtask

    task automatic idle_gap(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(done == 1'b1 && pass_cn1 == 1'b1 && pass_cn2 == 1'b1 && scan_out == 1'b0,
                "R9", "idle hold", {done, pass_cn1, pass_cn2, scan_out}, 14);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_up();
    end

    initial begin
        int unsigned r;
        int ab;
        r = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        chk({busy, done, pass_cn1, pass_cn2, scan_out} == 5'b0, "R1", "outputs in reset",
            {busy, done, pass_cn1, pass_cn2, scan_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, pass_cn1, pass_cn2, scan_out} == 5'b0, "R1", "outputs after reset",
            {busy, done, pass_cn1, pass_cn2, scan_out}, 0);

        run_seq(0);
        idle_gap(3);
        run_seq(1);
        idle_gap(1);
        run_seq(T - 1);
        run_seq(2 * W + N + 2);
        for (int it = 0; it < 8; it++) begin
            idle_gap($urandom_range(0, 5));
            ab = ($urandom % 2 == 0) ? int'($urandom_range(1, T - 1)) : 0;
            run_seq(ab);
        end
        idle_gap(2);
        finish_up();
    end

endmodule